// File: doc/BRIEF.md
# Pending Line-Fill Request Table

This block sits between a group of caches and a slow memory on a split-transaction bus. A cache that misses submits a line-fill request carrying a line address and its own cache index. The table keeps each outstanding fetch in an entry, sends entries to memory one at a time, and, when memory returns a response tagged with an entry index, signals the completion to every cache recorded against that line in a single cycle.

When a second cache asks for a line that is already pending, no new fetch is created. The request joins the existing entry as one more waiter, so memory reads the line once and the one response serves every waiter. A separate lookup port tells a cache's snoop logic whether that cache is waiting on a given line. The snoop logic uses this to refuse a conflicting exclusive request on the snoop bus rather than give way and retry forever.

Top module: `prt_table`

## Requirements
- R1: After reset no entry is pending. `mem_req_valid_o`, `cpl_valid_o` and `qry_hit_o` are low, and both counters read zero.
- R2: A request whose line matches no pending entry, while an entry is free, is accepted in the same cycle with `req_alloc_o`. It takes the lowest-numbered free entry, records the requester as its only waiter and queues the entry for memory.
- R3: A request whose line matches a pending entry (issued or not, and even with the table full) is answered with `req_merged_o`. It adds the requester to that entry's waiter set and creates no memory request.
- R4: A request that matches nothing while all entries are in use is answered with `req_busy_o` and leaves the table unchanged.
- R5: Entries are offered on `mem_req_valid_o` in allocation order, one per cycle in which `mem_req_ready_i` is high. `mem_req_tag_o` carries the entry index and `mem_req_addr_o` carries the line, and both are held while the offer waits.
- R6: A response on `mem_rsp_valid_i` whose `mem_rsp_tag_i` names an issued, pending entry raises `cpl_valid_o` in the same cycle. `cpl_waiters_o` has bit i set for every cache i waiting on that line, and `cpl_addr_o` gives the line. The entry is free from the next cycle.
- R7: A response whose tag names a free entry, or one not yet sent to memory, produces no completion and changes nothing.
- R8: `qry_hit_o` is high in the same cycle exactly when the line on `qry_addr_i` is pending with cache `qry_id_i` among its waiters.
- R9: `cpl_count_o` rises by one for each completion and `merge_count_o` by one for each merged request. Each counter updates one cycle after the event and wraps.
- R10: A request for a line whose entry completes in the same cycle is not merged and is not in that completion's waiter set. It is treated as a new line: allocated if an entry is free, refused otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Line-fill request present |
| req_addr_i | input | ADDR_W | Requested line address |
| req_id_i | input | ID_W | Requesting cache index |
| req_alloc_o | output | 1 | Request took a new entry |
| req_merged_o | output | 1 | Request joined a pending entry |
| req_busy_o | output | 1 | Request refused, table full |
| mem_req_valid_o | output | 1 | Fetch offered to memory |
| mem_req_ready_i | input | 1 | Memory takes the offered fetch |
| mem_req_addr_o | output | ADDR_W | Line address of offered fetch |
| mem_req_tag_o | output | TAG_W | Entry index of offered fetch |
| mem_rsp_valid_i | input | 1 | Memory response present |
| mem_rsp_tag_i | input | TAG_W | Entry index of the response |
| cpl_valid_o | output | 1 | Completion broadcast |
| cpl_addr_o | output | ADDR_W | Completed line address |
| cpl_waiters_o | output | NUM_CACHES | Caches released by the completion |
| qry_addr_i | input | ADDR_W | Snoop lookup line address |
| qry_id_i | input | ID_W | Snoop lookup cache index |
| qry_hit_o | output | 1 | That cache waits on that line |
| cpl_count_o | output | CNT_W | Completed fetches |
| merge_count_o | output | CNT_W | Merged requests |

## Verification
A lost waiter bit shows up as a missing bit in `cpl_waiters_o` at that entry's completion, and `qry_hit_o` shows it at once for the cache concerned. A stale valid or address field shows up on the next request for that line as an allocation where a merge was due, which also adds an extra fetch on the memory side. A fault in the issue order or in the issued flag shows up on `mem_req_tag_o` within a handful of cycles, or as a completion that fires for a response that should have been ignored. All of these appear at the ports no later than the next request, offer or response that touches the affected entry.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_ALLOC = 2'd1,
    OUT_MERGE = 2'd2,
    OUT_BUSY  = 2'd3
  } req_out_e;
endpackage

// File: rtl/prt_pick.sv
// Lowest-index selector over a bit vector.
module prt_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/prt_cam.sv
// Parallel line-address compare against all entries.
module prt_cam #(
  parameter int N  = 8,
  parameter int AW = 26
) (
  input  logic [N-1:0]  ent_en_i,
  input  logic [AW-1:0] ent_addr_i [N],
  input  logic [AW-1:0] key_i,
  output logic [N-1:0]  hit_vec_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g] = ent_en_i[g] && (ent_addr_i[g] == key_i);
  end
endmodule

// File: rtl/prt_issue_fifo.sv
// Holds entry indices in allocation order until memory takes them.
module prt_issue_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (push_i && wr_q == PW'(g))      mem_q[g] <= push_data_i;
    end
  end
endmodule

// File: rtl/prt_table.sv
module prt_table #(
  parameter int NUM_CACHES  = 4,
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 26,
  parameter int CNT_W       = 16,
  localparam int ID_W       = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
  localparam int TAG_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [ID_W-1:0]       req_id_i,
  output logic                  req_alloc_o,
  output logic                  req_merged_o,
  output logic                  req_busy_o,
  output logic                  mem_req_valid_o,
  input  logic                  mem_req_ready_i,
  output logic [ADDR_W-1:0]     mem_req_addr_o,
  output logic [TAG_W-1:0]      mem_req_tag_o,
  input  logic                  mem_rsp_valid_i,
  input  logic [TAG_W-1:0]      mem_rsp_tag_i,
  output logic                  cpl_valid_o,
  output logic [ADDR_W-1:0]     cpl_addr_o,
  output logic [NUM_CACHES-1:0] cpl_waiters_o,
  input  logic [ADDR_W-1:0]     qry_addr_i,
  input  logic [ID_W-1:0]       qry_id_i,
  output logic                  qry_hit_o,
  output logic [CNT_W-1:0]      cpl_count_o,
  output logic [CNT_W-1:0]      merge_count_o
);
  import prt_pkg::*;

  logic [NUM_ENTRIES-1:0] valid_q, issued_q;
  logic [ADDR_W-1:0]      addr_q [NUM_ENTRIES];
  logic [NUM_CACHES-1:0]  wait_q [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] cpl_vec, matchable, req_hit_vec, qry_hit_vec, qry_wait_vec;
  logic [TAG_W-1:0]       merge_idx, alloc_idx, head_idx;
  logic                   merge_any, free_any, fifo_empty, issue_fire, cpl_hit;
  logic [NUM_CACHES-1:0]  req_oh;
  req_out_e               outcome;
  logic [CNT_W-1:0]       cpl_cnt_q, merge_cnt_q;

  // Completion: response must name a pending entry already sent to memory.
  assign cpl_hit   = mem_rsp_valid_i && valid_q[mem_rsp_tag_i] && issued_q[mem_rsp_tag_i];
  assign cpl_vec   = cpl_hit ? (NUM_ENTRIES'(1) << mem_rsp_tag_i) : '0;
  // An entry retiring this cycle cannot absorb a new waiter.
  assign matchable = valid_q & ~cpl_vec;

  prt_cam #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_req_cam (
    .ent_en_i  (matchable),
    .ent_addr_i(addr_q),
    .key_i     (req_addr_i),
    .hit_vec_o (req_hit_vec)
  );

  prt_cam #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_qry_cam (
    .ent_en_i  (valid_q),
    .ent_addr_i(addr_q),
    .key_i     (qry_addr_i),
    .hit_vec_o (qry_hit_vec)
  );

  prt_pick #(.N(NUM_ENTRIES)) u_merge_pick (
    .vec_i(req_hit_vec),
    .idx_o(merge_idx),
    .any_o(merge_any)
  );

  prt_pick #(.N(NUM_ENTRIES)) u_free_pick (
    .vec_i(~valid_q),
    .idx_o(alloc_idx),
    .any_o(free_any)
  );

  always_comb begin
    outcome = OUT_NONE;
    if (req_valid_i) begin
      if (merge_any)     outcome = OUT_MERGE;
      else if (free_any) outcome = OUT_ALLOC;
      else               outcome = OUT_BUSY;
    end
  end

  assign req_alloc_o  = (outcome == OUT_ALLOC);
  assign req_merged_o = (outcome == OUT_MERGE);
  assign req_busy_o   = (outcome == OUT_BUSY);
  assign req_oh       = NUM_CACHES'(1) << req_id_i;

  prt_issue_fifo #(.DEPTH(NUM_ENTRIES), .W(TAG_W)) u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (req_alloc_o),
    .push_data_i(alloc_idx),
    .pop_i      (issue_fire),
    .head_o     (head_idx),
    .empty_o    (fifo_empty)
  );

  assign mem_req_valid_o = !fifo_empty;
  assign mem_req_tag_o   = head_idx;
  assign mem_req_addr_o  = addr_q[head_idx];
  assign issue_fire      = mem_req_valid_o && mem_req_ready_i;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g]  <= 1'b0;
        issued_q[g] <= 1'b0;
        addr_q[g]   <= '0;
        wait_q[g]   <= '0;
      end else if (cpl_vec[g]) begin
        valid_q[g]  <= 1'b0;
        issued_q[g] <= 1'b0;
        wait_q[g]   <= '0;
      end else if (req_alloc_o && alloc_idx == TAG_W'(g)) begin
        valid_q[g]  <= 1'b1;
        issued_q[g] <= 1'b0;
        addr_q[g]   <= req_addr_i;
        wait_q[g]   <= req_oh;
      end else begin
        if (req_merged_o && merge_idx == TAG_W'(g)) wait_q[g] <= wait_q[g] | req_oh;
        if (issue_fire && head_idx == TAG_W'(g))    issued_q[g] <= 1'b1;
      end
    end
    assign qry_wait_vec[g] = qry_hit_vec[g] && wait_q[g][qry_id_i];
  end

  assign qry_hit_o     = |qry_wait_vec;
  assign cpl_valid_o   = cpl_hit;
  assign cpl_addr_o    = cpl_hit ? addr_q[mem_rsp_tag_i] : '0;
  assign cpl_waiters_o = cpl_hit ? wait_q[mem_rsp_tag_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_cnt_q   <= '0;
      merge_cnt_q <= '0;
    end else begin
      if (cpl_hit)      cpl_cnt_q   <= cpl_cnt_q + CNT_W'(1);
      if (req_merged_o) merge_cnt_q <= merge_cnt_q + CNT_W'(1);
    end
  end

  assign cpl_count_o   = cpl_cnt_q;
  assign merge_count_o = merge_cnt_q;
endmodule

// File: rtl/prt_table_chk.sv
module prt_table_chk #(
  parameter int NUM_CACHES = 4,
  parameter int ADDR_W     = 26,
  parameter int TAG_W      = 3,
  parameter int CNT_W      = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_alloc_o,
  input logic                  req_merged_o,
  input logic                  req_busy_o,
  input logic                  mem_req_valid_o,
  input logic                  mem_req_ready_i,
  input logic [ADDR_W-1:0]     mem_req_addr_o,
  input logic [TAG_W-1:0]      mem_req_tag_o,
  input logic                  mem_rsp_valid_i,
  input logic                  cpl_valid_o,
  input logic [NUM_CACHES-1:0] cpl_waiters_o,
  input logic [CNT_W-1:0]      cpl_count_o,
  input logic [CNT_W-1:0]      merge_count_o
);
  assert_one_outcome_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $countones({req_alloc_o, req_merged_o, req_busy_o}) == 1);

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(req_alloc_o || req_merged_o || req_busy_o));

  assert_offer_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_tag_o) && $stable(mem_req_addr_o)));

  assert_cpl_has_waiter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> cpl_waiters_o != '0);

  assert_cpl_needs_rsp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> mem_rsp_valid_i);

  assert_cpl_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_count_o == CNT_W'($past(cpl_count_o) + CNT_W'($past(cpl_valid_o))));

  assert_merge_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_count_o == CNT_W'($past(merge_count_o) + CNT_W'($past(req_merged_o))));
endmodule

bind prt_table prt_table_chk #(
  .NUM_CACHES(NUM_CACHES), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_alloc_o    (req_alloc_o),
  .req_merged_o   (req_merged_o),
  .req_busy_o     (req_busy_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_req_tag_o  (mem_req_tag_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .cpl_valid_o    (cpl_valid_o),
  .cpl_waiters_o  (cpl_waiters_o),
  .cpl_count_o    (cpl_count_o),
  .merge_count_o  (merge_count_o)
);

// File: tb/tb_prt_table.sv
`timescale 1ns/1ps
module tb_prt_table;
  localparam int NC = 4;
  localparam int AW = 26;
  localparam int TW = 3;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_id = '0;
  logic req_alloc, req_merged, req_busy;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [TW-1:0] mem_req_tag;
  logic mem_rsp_valid = 1'b0;
  logic [TW-1:0] mem_rsp_tag = '0;
  logic cpl_valid;
  logic [AW-1:0] cpl_addr;
  logic [NC-1:0] cpl_waiters;
  logic [AW-1:0] qry_addr = '0;
  logic [1:0] qry_id = '0;
  logic qry_hit;
  logic [CW-1:0] cpl_count, merge_count;

  always #5 clk = ~clk;

  prt_table dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_id_i(req_id),
    .req_alloc_o(req_alloc), .req_merged_o(req_merged), .req_busy_o(req_busy),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_req_tag_o(mem_req_tag),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_tag_i(mem_rsp_tag),
    .cpl_valid_o(cpl_valid), .cpl_addr_o(cpl_addr), .cpl_waiters_o(cpl_waiters),
    .qry_addr_i(qry_addr), .qry_id_i(qry_id), .qry_hit_o(qry_hit),
    .cpl_count_o(cpl_count), .merge_count_o(merge_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // outcome codes: 1 alloc, 2 merge, 3 busy
  typedef struct packed {
    logic [15:0] addr;
    logic [1:0]  id;
    logic [1:0]  res;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{16'h0100, 2'd0, 2'd1},
    '{16'h0100, 2'd1, 2'd2},
    '{16'h0200, 2'd2, 2'd1},
    '{16'h0100, 2'd3, 2'd2},
    '{16'h0300, 2'd0, 2'd1},
    '{16'h0400, 2'd1, 2'd1},
    '{16'h0500, 2'd2, 2'd1},
    '{16'h0600, 2'd3, 2'd1},
    '{16'h0700, 2'd0, 2'd1},
    '{16'h0800, 2'd2, 2'd1},
    '{16'h0900, 2'd2, 2'd3},
    '{16'h0800, 2'd3, 2'd2},
    '{16'h0200, 2'd2, 2'd2}
  };

  task automatic query(input logic [AW-1:0] a, input logic [1:0] id, input logic exp, input string req);
    @(negedge clk);
    qry_addr = a;
    qry_id = id;
    #1;
    check(req, 64'(qry_hit), 64'(exp));
  endtask

  task automatic respond(input logic [TW-1:0] tag, input logic [NC-1:0] exp_w, input logic [AW-1:0] exp_a);
    @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_tag = tag;
    #1;
    check("R6 cpl_valid", 64'(cpl_valid), 64'd1);
    check("R6 cpl_waiters", 64'(cpl_waiters), 64'(exp_w));
    check("R6 cpl_addr", 64'(cpl_addr), 64'(exp_a));
    @(posedge clk);
    #1;
    mem_rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    qry_addr = 26'h100;
    #1;
    // R1 reset state
    check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    check("R1 cpl_valid", 64'(cpl_valid), 64'd0);
    check("R1 qry_hit", 64'(qry_hit), 64'd0);
    check("R1 cpl_count", 64'(cpl_count), 64'd0);
    check("R1 merge_count", 64'(merge_count), 64'd0);

    // R2 R3 R4 vector walk with memory stalled
    foreach (VEC[i]) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_addr = AW'(VEC[i].addr);
      req_id = VEC[i].id;
      #1;
      check(VEC[i].res == 2'd1 ? "R2 alloc" : (VEC[i].res == 2'd2 ? "R3 merge" : "R4 busy"),
            64'({req_busy, req_merged, req_alloc}),
            64'(VEC[i].res == 2'd1 ? 3'b001 : (VEC[i].res == 2'd2 ? 3'b010 : 3'b100)));
      @(posedge clk);
      #1;
      req_valid = 1'b0;
    end
    check("R9 merge_count", 64'(merge_count), 64'd4);

    // R8 lookup
    query(26'h100, 2'd3, 1'b1, "R8 waiter present");
    query(26'h100, 2'd2, 1'b0, "R8 waiter absent");
    query(26'h900, 2'd2, 1'b0, "R4 refused line not held");
    query(26'h800, 2'd3, 1'b1, "R3 merged when full");

    // R7 response for an entry not yet sent
    @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_tag = 3'd0;
    #1;
    check("R7 no completion", 64'(cpl_valid), 64'd0);
    @(posedge clk);
    #1;
    mem_rsp_valid = 1'b0;
    query(26'h100, 2'd0, 1'b1, "R7 entry kept");

    // R5 allocation order, exactly eight fetches
    @(negedge clk);
    mem_req_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #1;
      check("R5 offer valid", 64'(mem_req_valid), 64'd1);
      check("R5 offer addr", 64'(mem_req_addr), 64'((k + 1) * 'h100));
      check("R5 offer tag", 64'(mem_req_tag), 64'(k));
      @(negedge clk);
    end
    mem_req_ready = 1'b0;
    #1;
    check("R3 no extra fetch", 64'(mem_req_valid), 64'd0);

    // R6 completions, out of order
    respond(3'd0, 4'b1011, 26'h100);
    query(26'h100, 2'd0, 1'b0, "R6 entry freed");
    check("R9 cpl_count", 64'(cpl_count), 64'd1);
    respond(3'd7, 4'b1100, 26'h800);
    respond(3'd1, 4'b0100, 26'h200);

    // R3 merge into an issued entry
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = 26'h400;
    req_id = 2'd3;
    #1;
    check("R3 merge issued", 64'(req_merged), 64'd1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    respond(3'd3, 4'b1010, 26'h400);

    // R10 request to the line completing this cycle
    @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_tag = 3'd2;
    req_valid = 1'b1;
    req_addr = 26'h300;
    req_id = 2'd1;
    #1;
    check("R10 cpl_valid", 64'(cpl_valid), 64'd1);
    check("R10 waiters exclude new", 64'(cpl_waiters), 64'b0001);
    check("R10 alloc", 64'({req_busy, req_merged, req_alloc}), 64'b001);
    @(posedge clk);
    #1;
    mem_rsp_valid = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    mem_req_ready = 1'b1;
    #1;
    check("R10 new fetch valid", 64'(mem_req_valid), 64'd1);
    check("R10 new fetch addr", 64'(mem_req_addr), 64'h300);
    check("R2 lowest free entry", 64'(mem_req_tag), 64'd0);
    @(negedge clk);
    mem_req_ready = 1'b0;
    #1;
    check("R9 cpl_count final", 64'(cpl_count), 64'd5);
    check("R9 merge_count final", 64'(merge_count), 64'd5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule